// File: doc/BRIEF.md
# Parallel RGB Display Timing Generator

This block produces the raster timing for a parallel RGB panel that holds no frame memory, so every active pixel has to be delivered on every frame. A pixel-step enable is derived from the system clock by a fixed divider. Two counters walk across each line and down each frame and drive horizontal sync, vertical sync and a data-enable qualifier. Active-area pixel and line offsets are also brought out so that a downstream fetch stage knows which pixel to present.

Timing is described by four cumulative end positions per axis: sync, back porch, active region and total. Software writes them through a small register port into shadow copies. A reload control moves the shadows into the working set either on the next clock or at the start of vertical blanking, which is the first line after the active region. A programmable line-match pulse and a readable sync status let software pace its frame-buffer flips against the scan.

Top module: `rgb_raster_timer`

## Requirements
- R1: While the enable bit (bit 0 of register 0) is clear, the counters stay at zero, pclkEn, de and lineIrq are low, hPos and vPos are zero, and both sync pins sit at their inactive level.
- R2: While enabled, pclkEn is high for exactly one clock in every DIV clocks, starting DIV clocks after enable. The pixel and line counters move only in cycles where pclkEn is high.
- R3: Horizontal sync is active for pixel indices 0 up to and including the sync end value (register 1). A line holds (register 4 value + 1) pixel steps, and the pixel counter wraps to 0 when it is at or above that value.
- R4: Vertical sync is active for line indices 0 up to and including the vertical sync end value (register 5). A frame holds (register 8 value + 1) lines, and the line counter wraps when it is at or above that value.
- R5: de is high only when the pixel index is above the back porch end (register 2) and at most the active end (register 3), and the line index is above register 6 and at most register 7. While de is high, hPos and vPos give the offsets inside the active area. Otherwise both are zero.
- R6: Bit 1 of register 0 makes horizontal sync active-high, and bit 2 does the same for vertical sync. When a bit is clear, that sync is active-low, which is the reset default.
- R7: lineIrq pulses for one clock, in the pclkEn cycle where the pixel index is 0 and the line index equals register 9.
- R8: Writing register 10 with bit 0 set copies all eight shadow timing values into the working set on the following clock edge. Bit 0 of register 10 reads 1 for exactly that one cycle and then reads 0.
- R9: Writing register 10 with bit 1 set marks a pending reload, which reads back as bit 1 of register 10. The copy and the clear happen on the pixel step from the last active line into the next line. Shadow writes have no effect on timing until a reload.
- R10: Reads are combinational on rdAddr. Register 0 returns the three control bits. Registers 1 to 8 return the shadow values. Register 9 returns the match line. Register 11 returns vertical sync active in bit 0, horizontal sync active in bit 1 and de in bit 2, all independent of polarity. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 16 | Register read data |
| pclkEn | output | 1 | Pixel step enable |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| de | output | 1 | Data-enable qualifier |
| hPos | output | 12 | Pixel offset within active area |
| vPos | output | 12 | Line offset within active area |
| lineIrq | output | 1 | Line-match interrupt pulse |

## Verification
A wrong counter or divider state shows up at the sync and de pins within one pixel step, and it moves every later edge of the raster, so a clock-by-clock reference comparison catches it at once. A wrong working timing set, such as a reload taken too early, too late or not at all, changes the hsync or de pattern from the first line that follows. The pending and immediate flags are read back through register 10 in every cycle around a reload, so a flag that clears on the wrong edge is seen in that same cycle.

// File: rtl/rgb_raster_pkg.sv
package rgb_raster_pkg;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int NTIME  = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_LINE   = 4'd9,
    A_RELOAD = 4'd10,
    A_STATUS = 4'd11
  } regAddr_e;

  typedef struct packed {
    logic [CNT_W-1:0] hSyncEnd;
    logic [CNT_W-1:0] hBpEnd;
    logic [CNT_W-1:0] hActEnd;
    logic [CNT_W-1:0] hTotEnd;
    logic [CNT_W-1:0] vSyncEnd;
    logic [CNT_W-1:0] vBpEnd;
    logic [CNT_W-1:0] vActEnd;
    logic [CNT_W-1:0] vTotEnd;
  } timing_t;

  typedef struct packed {
    logic run;
    logic hsHigh;
    logic vsHigh;
  } ctlStrobe_t;

  typedef struct packed {
    logic vblankEvt;
    logic hsActive;
    logic vsActive;
    logic de;
  } dpStatus_t;
endpackage

// File: rtl/rgb_raster_ctrl.sv
module rgb_raster_ctrl
  import rgb_raster_pkg::*;
#(
  parameter timing_t INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  dpStatus_t         dpStat,
  output ctlStrobe_t        strobe,
  output timing_t           tmOut,
  output logic [CNT_W-1:0]  irqLine
);
  logic [2:0]       ctrlR;
  logic             immPulse;
  logic             pending;
  logic [CNT_W-1:0] shadowR [NTIME];
  logic [CNT_W-1:0] activeR [NTIME];
  logic             copyNow;
  logic             reloadWr;
  timing_t          shadowPacked;

  assign reloadWr = wrEn && (wrAddr == A_RELOAD);
  assign copyNow  = immPulse || (dpStat.vblankEvt && pending);

  for (genvar i = 0; i < NTIME; i++) begin : g_timeReg
    localparam logic [CNT_W-1:0] RST_VAL = INIT[(NTIME-1-i)*CNT_W +: CNT_W];
    logic wrHit;
    assign wrHit = wrEn && (wrAddr == ADDR_W'(i + 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowR[i] <= RST_VAL;
        activeR[i] <= RST_VAL;
      end else begin
        if (wrHit) shadowR[i] <= wrData[CNT_W-1:0];
        if (copyNow) activeR[i] <= shadowR[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlR    <= '0;
      irqLine  <= '0;
      immPulse <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (wrEn && wrAddr == A_CTRL) ctrlR <= wrData[2:0];
      if (wrEn && wrAddr == A_LINE) irqLine <= wrData[CNT_W-1:0];
      immPulse <= reloadWr && wrData[0];
      if (dpStat.vblankEvt) pending <= 1'b0;
      if (reloadWr && wrData[1]) pending <= 1'b1;
    end
  end

  assign tmOut = {activeR[0], activeR[1], activeR[2], activeR[3],
                  activeR[4], activeR[5], activeR[6], activeR[7]};
  assign shadowPacked = {shadowR[0], shadowR[1], shadowR[2], shadowR[3],
                         shadowR[4], shadowR[5], shadowR[6], shadowR[7]};

  assign strobe.run    = ctrlR[0];
  assign strobe.hsHigh = ctrlR[1];
  assign strobe.vsHigh = ctrlR[2];

  always_comb begin
    rdData = '0;
    if (rdAddr >= ADDR_W'(1) && rdAddr <= ADDR_W'(NTIME)) begin
      rdData[CNT_W-1:0] = shadowR[rdAddr - ADDR_W'(1)];
    end else begin
      case (rdAddr)
        A_CTRL:   rdData[2:0] = ctrlR;
        A_LINE:   rdData[CNT_W-1:0] = irqLine;
        A_RELOAD: rdData[1:0] = {pending, immPulse};
        A_STATUS: rdData[2:0] = {dpStat.de, dpStat.hsActive, dpStat.vsActive};
        default:  rdData = '0;
      endcase
    end
  end

  // R8: an immediate request loads the shadow set on the next edge
  a_r8_imm_copy: assert property (@(posedge clk) disable iff (!rstN)
    immPulse |=> (tmOut == $past(shadowPacked)));
  // R8: the request flag lasts one cycle unless written again
  a_r8_imm_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (immPulse && !(reloadWr && wrData[0])) |=> !immPulse);
  // R9: pending clears at vertical blanking start
  a_r9_pending_clear: assert property (@(posedge clk) disable iff (!rstN)
    (pending && dpStat.vblankEvt && !(reloadWr && wrData[1])) |=> !pending);
  // R9: working set holds without a reload
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!immPulse && !(pending && dpStat.vblankEvt)) |=> $stable(tmOut));
endmodule

// File: rtl/rgb_raster_dp.sv
module rgb_raster_dp
  import rgb_raster_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  timing_t          tm,
  input  ctlStrobe_t       strobe,
  input  logic [CNT_W-1:0] irqLine,
  output dpStatus_t        dpStat,
  output logic             pclkEn,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CNT_W-1:0] hPos,
  output logic [CNT_W-1:0] vPos,
  output logic             lineIrq
);
  localparam int DIV_W = $clog2(DIV) + 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] hCnt;
  logic [CNT_W-1:0] vCnt;
  logic             pixEn;
  logic             lineEnd;
  logic             hsAct;
  logic             vsAct;
  logic             hIn;
  logic             vIn;

  assign pixEn   = strobe.run && (divCnt == DIV_LAST);
  assign lineEnd = hCnt >= tm.hTotEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      hCnt   <= '0;
      vCnt   <= '0;
    end else if (!strobe.run) begin
      divCnt <= '0;
      hCnt   <= '0;
      vCnt   <= '0;
    end else begin
      divCnt <= pixEn ? '0 : divCnt + DIV_W'(1);
      if (pixEn) begin
        if (lineEnd) begin
          hCnt <= '0;
          vCnt <= (vCnt >= tm.vTotEnd) ? '0 : vCnt + CNT_W'(1);
        end else begin
          hCnt <= hCnt + CNT_W'(1);
        end
      end
    end
  end

  assign hsAct = strobe.run && (hCnt <= tm.hSyncEnd);
  assign vsAct = strobe.run && (vCnt <= tm.vSyncEnd);
  assign hIn   = (hCnt > tm.hBpEnd) && (hCnt <= tm.hActEnd);
  assign vIn   = (vCnt > tm.vBpEnd) && (vCnt <= tm.vActEnd);
  assign de    = strobe.run && hIn && vIn;
  assign hPos  = de ? hCnt - tm.hBpEnd - CNT_W'(1) : '0;
  assign vPos  = de ? vCnt - tm.vBpEnd - CNT_W'(1) : '0;
  assign hsync = strobe.hsHigh ? hsAct : ~hsAct;
  assign vsync = strobe.vsHigh ? vsAct : ~vsAct;
  assign pclkEn  = pixEn;
  assign lineIrq = pixEn && (hCnt == '0) && (vCnt == irqLine);

  assign dpStat.vblankEvt = pixEn && lineEnd && (vCnt == tm.vActEnd);
  assign dpStat.hsActive  = hsAct;
  assign dpStat.vsActive  = vsAct;
  assign dpStat.de        = de;

  // R1: nothing moves while disabled
  a_r1_idle_off: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |-> (!pclkEn && !de && !lineIrq));
  // R2: counters hold between pixel steps
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !pixEn) |=> ($stable(hCnt) && $stable(vCnt)));
  // R3: line wraps after the last pixel
  a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && lineEnd) |=> (hCnt == '0));

  if (DIV > 1) begin : g_irqCheck
    // R7: line interrupt lasts one clock
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
      lineIrq |=> !lineIrq);
  end
endmodule

// File: rtl/rgb_raster_timer.sv
module rgb_raster_timer
  import rgb_raster_pkg::*;
#(
  parameter int DIV        = 2,
  parameter int H_SYNC_END = 1,
  parameter int H_BP_END   = 4,
  parameter int H_ACT_END  = 12,
  parameter int H_TOT_END  = 14,
  parameter int V_SYNC_END = 0,
  parameter int V_BP_END   = 2,
  parameter int V_ACT_END  = 6,
  parameter int V_TOT_END  = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic [3:0]  rdAddr,
  output logic [15:0] rdData,
  output logic        pclkEn,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic [11:0] hPos,
  output logic [11:0] vPos,
  output logic        lineIrq
);
  localparam timing_t INIT_T = '{
    hSyncEnd: CNT_W'(H_SYNC_END), hBpEnd: CNT_W'(H_BP_END),
    hActEnd:  CNT_W'(H_ACT_END),  hTotEnd: CNT_W'(H_TOT_END),
    vSyncEnd: CNT_W'(V_SYNC_END), vBpEnd: CNT_W'(V_BP_END),
    vActEnd:  CNT_W'(V_ACT_END),  vTotEnd: CNT_W'(V_TOT_END)};

  timing_t          tm;
  ctlStrobe_t       strobe;
  dpStatus_t        dpStat;
  logic [CNT_W-1:0] irqLine;

  rgb_raster_ctrl #(.INIT(INIT_T)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .dpStat(dpStat), .strobe(strobe),
    .tmOut(tm), .irqLine(irqLine));

  rgb_raster_dp #(.DIV(DIV)) u_dp (
    .clk(clk), .rstN(rstN), .tm(tm), .strobe(strobe), .irqLine(irqLine),
    .dpStat(dpStat), .pclkEn(pclkEn), .hsync(hsync), .vsync(vsync), .de(de),
    .hPos(hPos), .vPos(vPos), .lineIrq(lineIrq));
endmodule

// File: tb/rgb_raster_timer_bench.sv
module rgb_raster_timer_bench;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  rdAddr = 4'd11;
  logic [15:0] rdData;
  logic        pclkEn, hsync, vsync, de, lineIrq;
  logic [11:0] hPos, vPos;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  rgb_raster_timer u_rgb_raster_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pclkEn(pclkEn), .hsync(hsync),
    .vsync(vsync), .de(de), .hPos(hPos), .vPos(vPos), .lineIrq(lineIrq));

  always #2 clk = ~clk;

  // reference model state
  int initT[8] = '{1, 4, 12, 14, 0, 2, 6, 7};
  int actM[8];
  int shM[8];
  int ctrlM, irqM, immM, pendM, divM, hc, vc;

  task automatic chk(string tag, int got, int exp);
    nCmp++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, got, exp);
    end
  endtask

  always @(posedge clk) begin
    int run, pix, evt, cp, hsA, vsA, deM, hpM, vpM, rdM, irqOut;
    if (!rstN) begin
      actM = initT; shM = initT;
      ctrlM = 0; irqM = 0; immM = 0; pendM = 0; divM = 0; hc = 0; vc = 0;
    end else begin
      run = ctrlM & 1;
      pix = (run != 0 && divM == DIV - 1) ? 1 : 0;
      evt = (pix != 0 && hc >= actM[3] && vc == actM[6]) ? 1 : 0;
      cp  = (immM != 0 || (evt != 0 && pendM != 0)) ? 1 : 0;
      if (run == 0) begin
        divM = 0; hc = 0; vc = 0;
      end else begin
        divM = (pix != 0) ? 0 : divM + 1;
        if (pix != 0) begin
          if (hc >= actM[3]) begin
            hc = 0;
            vc = (vc >= actM[7]) ? 0 : vc + 1;
          end else hc = hc + 1;
        end
      end
      if (cp != 0) actM = shM;
      if (evt != 0) pendM = 0;
      immM = (wrEn && wrAddr == 4'd10 && wrData[0]) ? 1 : 0;
      if (wrEn) begin
        if (wrAddr == 4'd0) ctrlM = int'(wrData[2:0]);
        else if (wrAddr >= 4'd1 && wrAddr <= 4'd8) shM[wrAddr - 1] = int'(wrData[11:0]);
        else if (wrAddr == 4'd9) irqM = int'(wrData[11:0]);
        else if (wrAddr == 4'd10 && wrData[1]) pendM = 1;
      end
    end
    #1;
    run = ctrlM & 1;
    pix = (run != 0 && divM == DIV - 1) ? 1 : 0;
    hsA = (run != 0 && hc <= actM[0]) ? 1 : 0;
    vsA = (run != 0 && vc <= actM[4]) ? 1 : 0;
    deM = (run != 0 && hc > actM[1] && hc <= actM[2] && vc > actM[5] && vc <= actM[6]) ? 1 : 0;
    hpM = (deM != 0) ? hc - actM[1] - 1 : 0;
    vpM = (deM != 0) ? vc - actM[5] - 1 : 0;
    irqOut = (pix != 0 && hc == 0 && vc == irqM) ? 1 : 0;
    case (rdAddr)
      4'd0:  rdM = ctrlM;
      4'd9:  rdM = irqM;
      4'd10: rdM = pendM * 2 + immM;
      4'd11: rdM = deM * 4 + hsA * 2 + vsA;
      default: rdM = (rdAddr <= 4'd8) ? shM[rdAddr - 1] : 0;
    endcase
    chk("R2 pclkEn", int'(pclkEn), pix);
    chk("R1/R3/R6 hsync", int'(hsync), ((ctrlM & 2) != 0) ? hsA : 1 - hsA);
    chk("R1/R4/R6 vsync", int'(vsync), ((ctrlM & 4) != 0) ? vsA : 1 - vsA);
    chk("R5/R9 de", int'(de), deM);
    chk("R5 hPos", int'(hPos), hpM);
    chk("R5 vPos", int'(vPos), vpM);
    chk("R7 lineIrq", int'(lineIrq), irqOut);
    if (rdAddr == 4'd10) chk("R8/R9 reload readback", int'(rdData), rdM);
    else chk("R10 rdData", int'(rdData), rdM);
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rstN = 1'b1;                  // R1: reset state compared above
    idle(10);
    wr(4'd0, 16'h0001);           // R2 R3 R4 R5: default raster
    idle(500);
    wr(4'd9, 16'd3);              // R7: match line 3
    wr(4'd0, 16'h0007);           // R6: active-high syncs
    idle(300);
    rdAddr = 4'd10;
    wr(4'd3, 16'd10);             // R9: shadow writes, no effect yet
    wr(4'd4, 16'd12);
    idle(200);
    wr(4'd10, 16'h0002);          // R9: reload at vertical blanking
    idle(500);
    wr(4'd7, 16'd4);              // R8: immediate reload mid-frame
    wr(4'd8, 16'd5);
    wr(4'd10, 16'h0001);
    idle(300);
    wr(4'd0, 16'h0000);           // R1: disable mid-frame
    idle(30);
    wr(4'd0, 16'h0003);
    idle(200);
    for (int a = 0; a < 16; a++) begin  // R10: read map sweep
      rdAddr = 4'(a);
      idle(3);
    end
    rdAddr = 4'd11;
    idle(50);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule